// File: doc/BRIEF.md
# Page ECC Result Tally

This block sits behind a BCH decoder and folds the per-packet decode results of one flash page into a single summary word for software. A page opens with a start pulse. The first packet result that arrives is recorded on its own: its decode-ok flag and its corrected-bit count. Every later packet is folded into one combined decode-ok flag and one running maximum of corrected bits.

The last packet result comes with an end pulse. That pulse closes the page and, one cycle later, raises a single-cycle done flag. If the end pulse also signals that the page was found erased, an empty bit is set and the page summary reports zero errors. The summary word, the page-level maximum and the page-level ok flag then hold until the next start pulse, so software can read them at leisure. Packet strobes that arrive outside an open page are ignored.

Top module: `ecc_page_tally`

## Requirements
- R1: After reset, `status` is all zeros, `done` is 0, `page_ok` is 0 and `page_max` is 0.
- R2: The first packet result after a start pulse is stored in the low byte of `status`. Bit 7 holds its decode-ok flag and bits 5:0 hold its corrected count.
- R3: Bit 15 of `status` is the AND of the decode-ok flags of all later packets in the page. It is 1 at page start, including when a page has no later packets.
- R4: Bits 13:8 of `status` hold the largest corrected count among the later packets, and 0 if there are none.
- R5: A corrected count above 63 is recorded as 63 in both the first-packet field and the later-packet field.
- R6: When `page_erased` is high together with `page_end`, bit 16 of `status` is set. `page_max` then reads 0 and `page_ok` reads 1.
- R7: For a page that is not erased, `page_max` is the larger of the two count fields, and `page_ok` is 1 only when bits 7 and 15 are both set.
- R8: `done` is high for exactly one cycle, in the cycle after the clock edge that samples `page_end` on an open page. The last packet may share that cycle with `page_end`.
- R9: From page close until the next start pulse, `status` does not change, and packet strobes have no effect on it.
- R10: A start pulse clears the record to the state `status` = 0x08000. A packet strobe in the same cycle as the start pulse counts as the first packet of the new page.

Bits 6 and 14 of `status` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_start | input | 1 | Opens a new page and clears the record |
| pkt_valid | input | 1 | Packet result strobe |
| pkt_ok | input | 1 | Decode-ok flag of the strobed packet |
| pkt_errs | input | CNT_IN_W | Corrected-bit count of the strobed packet |
| page_end | input | 1 | Closes the page; may coincide with the last packet |
| page_erased | input | 1 | Page found erased, sampled with `page_end` |
| status | output | 17 | Page summary word |
| page_max | output | 6 | Page-level corrected count |
| page_ok | output | 1 | Page-level decode-ok |
| done | output | 1 | One-cycle pulse after page close |

## Verification
The hardest cases to reach are the collisions. One is a start pulse, a packet strobe and an end pulse all in the same cycle, which tests R10 and R8 together. The other is a page with no later packets, where bit 15 must still read 1. Both are driven as directed pages. Random pages with idle gaps, occasional decode failures and counts drawn from above the saturation limit cover the folding and clamping. After each page close, a stray packet strobe is sent and the word is checked for any change.

// File: rtl/ecc_page_tally.sv
module ecc_page_tally #(
  parameter int CNT_IN_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                page_start,
  input  logic                pkt_valid,
  input  logic                pkt_ok,
  input  logic [CNT_IN_W-1:0] pkt_errs,
  input  logic                page_end,
  input  logic                page_erased,
  output logic [16:0]         status,
  output logic [5:0]          page_max,
  output logic                page_ok,
  output logic                done
);

  localparam int FW = 6;
  localparam logic [FW-1:0] SAT = '1;

  logic          open_q, seen_q, f_ok_q, r_ok_q, empty_q, done_q;
  logic [FW-1:0] f_cnt_q, r_max_q;

  logic          open_b, seen_b, f_ok_b, r_ok_b, empty_b;
  logic [FW-1:0] f_cnt_b, r_max_b;
  logic          take, close;
  logic [FW-1:0] clip;

  assign clip = (pkt_errs > CNT_IN_W'(SAT)) ? SAT : pkt_errs[FW-1:0];

  always_comb begin
    if (page_start) begin
      open_b = 1'b1; seen_b = 1'b0; f_ok_b = 1'b0; f_cnt_b = '0;
      r_ok_b = 1'b1; r_max_b = '0;  empty_b = 1'b0;
    end else begin
      open_b = open_q; seen_b = seen_q; f_ok_b = f_ok_q; f_cnt_b = f_cnt_q;
      r_ok_b = r_ok_q; r_max_b = r_max_q; empty_b = empty_q;
    end
  end

  assign take  = pkt_valid & open_b;
  assign close = page_end & open_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0; seen_q <= 1'b0; f_ok_q <= 1'b0; f_cnt_q <= '0;
      r_ok_q <= 1'b0; r_max_q <= '0;  empty_q <= 1'b0; done_q <= 1'b0;
    end else begin
      open_q  <= open_b & ~close;
      seen_q  <= seen_b | take;
      f_ok_q  <= (take && !seen_b) ? pkt_ok : f_ok_b;
      f_cnt_q <= (take && !seen_b) ? clip : f_cnt_b;
      r_ok_q  <= (take && seen_b) ? (r_ok_b & pkt_ok) : r_ok_b;
      r_max_q <= (take && seen_b && clip > r_max_b) ? clip : r_max_b;
      empty_q <= close ? page_erased : empty_b;
      done_q  <= close;
    end
  end

  assign status   = {empty_q, r_ok_q, 1'b0, r_max_q, f_ok_q, 1'b0, f_cnt_q};
  assign page_max = empty_q ? '0 : ((f_cnt_q > r_max_q) ? f_cnt_q : r_max_q);
  assign page_ok  = empty_q | (f_ok_q & r_ok_q);
  assign done     = done_q;

  a_r8_done_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
    (page_end && (open_q || page_start)) |=> done);
  a_r8_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(page_end));
  a_r9_hold_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !page_start) |=> $stable(status));
  a_r3_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !page_start && !status[15]) |=> !status[15]);
  a_r4_max_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !page_start) |=> (status[13:8] >= $past(status[13:8])));
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (page_start && !pkt_valid && !page_end) |=> (status == 17'h08000));
  a_r6_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (page_end && page_erased && (open_q || page_start)) |=> (status[16] && page_ok && page_max == 6'd0));

endmodule

// File: tb/test_ecc_page_tally.sv
module test_ecc_page_tally;
  logic clk = 1'b0, rst_n = 1'b0;
  logic page_start = 0, pkt_valid = 0, pkt_ok = 0, page_end = 0, page_erased = 0;
  logic [7:0] pkt_errs = '0;
  logic [16:0] status;
  logic [5:0] page_max;
  logic page_ok, done;

  int checks = 0, fails = 0;
  bit m_seen, m_fok, m_rok, m_empty;
  int m_fcnt, m_rmax;

  always #10 clk = ~clk;

  ecc_page_tally #(.CNT_IN_W(8)) i_ecc_page_tally (
    .clk, .rst_n, .page_start, .pkt_valid, .pkt_ok, .pkt_errs,
    .page_end, .page_erased, .status, .page_max, .page_ok, .done);

  function automatic int sat63(int v); return (v > 63) ? 63 : v; endfunction
  function automatic logic [16:0] exp_status();
    return {m_empty, m_rok, 1'b0, 6'(m_rmax), m_fok, 1'b0, 6'(m_fcnt)};
  endfunction
  function automatic int exp_max();
    if (m_empty) return 0;
    return (m_fcnt > m_rmax) ? m_fcnt : m_rmax;
  endfunction
  function automatic bit exp_ok(); return m_empty | (m_fok & m_rok); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_seen = 0; m_fok = 0; m_fcnt = 0; m_rok = 1; m_rmax = 0; m_empty = 0;
  endtask
  task automatic model_pkt(bit ok, int cnt);
    if (!m_seen) begin m_fok = ok; m_fcnt = sat63(cnt); m_seen = 1; end
    else begin m_rok = m_rok & ok; if (sat63(cnt) > m_rmax) m_rmax = sat63(cnt); end
  endtask

  task automatic idle();
    page_start = 0; pkt_valid = 0; pkt_ok = 0; pkt_errs = '0; page_end = 0; page_erased = 0;
  endtask

  task automatic check_close(string tag);
    @(negedge clk); idle();
    chk({tag, " R8 done"}, done, 1);
    chk({tag, " R2/R3/R4/R5/R6 status"}, status, exp_status());
    chk({tag, " R7 page_max"}, page_max, exp_max());
    chk({tag, " R7 page_ok"}, page_ok, exp_ok());
    pkt_valid = 1; pkt_ok = 0; pkt_errs = 8'd50;
    @(negedge clk); idle();
    chk({tag, " R8 done single"}, done, 0);
    chk({tag, " R9 stray ignored"}, status, exp_status());
  endtask

  task automatic run_page(int n, bit erased, int fail_pct, int cmax, string tag);
    @(negedge clk); idle(); page_start = 1; model_clear();
    if (n == 0) begin
      @(negedge clk); idle(); page_end = 1; page_erased = erased;
      m_empty = erased;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk); idle();
      if ($urandom_range(0, 3) == 0 && i != 0) begin @(negedge clk); idle(); end
      pkt_valid = 1;
      pkt_ok = ($urandom_range(0, 99) >= fail_pct);
      pkt_errs = 8'($urandom_range(0, cmax));
      model_pkt(pkt_ok, int'(pkt_errs));
      if (i == n - 1) begin page_end = 1; page_erased = erased; m_empty = erased; end
    end
    check_close(tag);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 status", status, 0);
        chk("R1 done", done, 0);
        chk("R1 page_ok", page_ok, 0);
        chk("R1 page_max", page_max, 0);
        void'($urandom(32'd1234));

        @(negedge clk); idle(); page_start = 1; model_clear();
        @(negedge clk); idle();
        chk("R10 clear", status, 17'h08000);

        run_page(1, 0, 0, 40, "single");
        run_page(0, 0, 0, 0, "empty-no-pkts");
        run_page(4, 1, 30, 255, "erased");

        @(negedge clk); idle(); page_start = 1; page_end = 1;
        pkt_valid = 1; pkt_ok = 1; pkt_errs = 8'd5;
        model_clear(); model_pkt(1, 5);
        check_close("R10 start+pkt+end");

        @(negedge clk); idle(); page_start = 1; model_clear();
        @(negedge clk); idle(); pkt_valid = 1; pkt_ok = 1; pkt_errs = 8'd200; model_pkt(1, 200);
        @(negedge clk); idle(); pkt_valid = 1; pkt_ok = 1; pkt_errs = 8'd64;  model_pkt(1, 64);
        @(negedge clk); idle(); pkt_valid = 1; pkt_ok = 1; pkt_errs = 8'd63;  model_pkt(1, 63);
        page_end = 1;
        check_close("R5 saturate");

        for (int p = 0; p < 60; p++)
          run_page($urandom_range(1, 9), ($urandom_range(0, 7) == 0), 10, 80, "random");
      end
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule